// File: doc/BRIEF.md
# Quadrature-Phase Fractional Clock Divider

This block turns four quarter-period-spaced copies of one input clock into a single divided clock whose period is N/4 input periods. N is 3, 5 or 7, so the ratios are 0.75, 1.25 and 1.75. Each of the four phases runs its own modulo-N counter. Each counter emits one pulse per N cycles of its own phase, at a slot chosen so that the four pulse trains interleave evenly. The four pulse trains are merged with an OR. The ratio is changed only by loading a new modulus. The slot offsets follow from it, and the merge structure stays the same.

A pulse is opened by a toggle flop clocked by the path's own phase. It is closed by a follower flop clocked by the opposite phase, half an input period later. Together these act as a set-reset latch whose set side runs on the path's own phase. Enable and modulus are captured in the phase-0 domain. Paths 1 to 3 re-time enable on their own phases, so all four paths start on one common timeline. Per-path rising-edge and falling-edge delay-trim codes are registered in the phase-0 domain and brought out to feed external delay cells.

Top module: `fdiv_quad`

## Requirements
- R1: Reset is synchronous and active-low on every phase. While reset is held, and afterwards while enable stays low, `div_out` stays low and shows no rising edge. The trim outputs read zero after reset.
- R2: `n_sel` encodes the modulus as 2'b00 = 3, 2'b01 = 5 and 2'b10 = 7. After reset the modulus is 5. With enable high, `div_out` shows exactly 4 rising edges for every N rising edges of phase 0.
- R3: Consecutive rising edges of `div_out` are N quarter input periods apart (15, 25 or 35 ns at a 20 ns input period).
- R4: Each `div_out` pulse stays high for half an input period (10 ns).
- R5: The encoding 2'b11 on `n_sel` is ignored, and the modulus in force stays unchanged.
- R6: A new modulus takes effect only while enable is low. Changes on `n_sel` while the divider runs leave the output period unchanged. The pending value is adopted once enable has been low.
- R7: Take the phase-0 rising edge just before `en` is raised. The first rising edge of `div_out` comes exactly two phase-0 periods after it, for every N.
- R8: After `en` falls, pulses end within two phase-0 periods, and `div_out` then stays low with no rising edge.
- R9: `trim_q` copies `trim_in` on each phase-0 rising edge. The field for path k, direction d (0 = rising, 1 = falling) sits at bits [(2k+d)*TRIM_W +: TRIM_W].
- R10: Reset asserted during operation forces `div_out` low by one phase-0 period after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk | input | 4 | Four copies of the input clock; bit k lags bit 0 by k quarter periods |
| rst_n | input | 1 | Synchronous active-low reset, seen on every phase |
| en | input | 1 | Runs the divider when high |
| n_sel | input | 2 | Modulus select: 00 = 3, 01 = 5, 10 = 7, 11 ignored |
| trim_in | input | 8*TRIM_W | Per-path rising and falling delay-trim codes |
| div_out | output | 1 | Merged fractional-ratio output clock |
| trim_q | output | 8*TRIM_W | Registered trim codes for the external delay cells |

## Verification
Enable and select pass through one phase-0 register. Path 0 fires on the next enabled edge, so the first output edge is due exactly 40 ns after the phase-0 edge that precedes `en`. The bench measures this latency against that edge. It drives every input 2.5 ns after a phase-0 edge, off the 5 ns grid on which all four phases switch. It samples levels at the same offset, so no sample falls on an edge. Ratio checks count output edges only after an eight-cycle settle, over windows of 24·N phase-0 periods, so each window always holds 96 edges. Spacing and width come from output edge timestamps. Trim codes are read one phase-0 edge after they are driven.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
// fdiv_pkg: shared constants, the modulus-select encoding and the slot
// function that places each path's pulse in the merged output.
// Assumes exactly four phases at quarter-period spacing.
package fdiv_pkg;

    localparam int NPH = 4;   // quadrature phases
    localparam int CW  = 3;   // counter width, holds N up to 7

    typedef enum logic [1:0] {
        NSEL_3    = 2'b00,
        NSEL_5    = 2'b01,
        NSEL_7    = 2'b10,
        NSEL_RSVD = 2'b11
    } nsel_e;

    // Pulse j of a frame lands at j*N/4 input periods. It falls on phase
    // (j*N mod 4) in cycle floor(j*N/4) of that phase's counter. Return
    // that cycle for phase k.
    function automatic logic [CW-1:0] slot_of(input logic [CW-1:0] n, input int k);
        int nn;
        nn = int'(n);
        for (int j = 0; j < NPH; j++) begin
            if (((j * nn) % NPH) == k) begin
                return CW'((j * nn) / NPH);
            end
        end
        return '0;
    endfunction

endpackage

// File: rtl/fdiv_ctrl.sv
`timescale 1ns/1ps
// fdiv_ctrl: phase-0 domain control. It registers enable, holds the active
// modulus, and registers the trim codes. Assumes phase 0 is free-running
// during reset. The modulus is reloaded only while the registered enable
// is low, so the paths never run on a mixed modulus.
module fdiv_ctrl
    import fdiv_pkg::*;
#(
    parameter int TW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    n_sel,
    input  logic [TW-1:0] trim_in,
    output logic          en_q,
    output logic [CW-1:0] n_act,
    output logic [TW-1:0] trim_q
);

    logic [CW-1:0] sel_n;
    logic          sel_ok;

    // Decode the select field; the reserved code is flagged as not usable.
    always_comb begin
        sel_ok = 1'b1;
        case (nsel_e'(n_sel))
            NSEL_3:  sel_n = CW'(3);
            NSEL_5:  sel_n = CW'(5);
            NSEL_7:  sel_n = CW'(7);
            default: begin
                sel_n  = CW'(5);
                sel_ok = 1'b0;
            end
        endcase
    end

    // Register enable and trim; load the modulus only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            n_act  <= CW'(5);
            trim_q <= '0;
        end else begin
            en_q   <= en;
            trim_q <= trim_in;
            if (!en_q && sel_ok) begin
                n_act <= sel_n;
            end
        end
    end

    // R2: the active modulus is always one of the legal values
    a_r2_legal_n : assert property (@(posedge clk) disable iff (!rst_n)
        (n_act == CW'(3)) || (n_act == CW'(5)) || (n_act == CW'(7)));

    // R5: the reserved select never alters the modulus
    a_r5_rsvd_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (n_sel == 2'b11) |=> $stable(n_act));

    // R6: no modulus change while running
    a_r6_hold_running : assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(n_act));

endmodule

// File: rtl/fdiv_path.sv
`timescale 1ns/1ps
// fdiv_path: one division path. A modulo-N counter on the path's own phase
// flips a set toggle in its slot cycle. A follower flop on the opposite
// phase copies that toggle half a period later. The XOR of the two is a
// pulse half an input period wide. Path 0 takes the phase-0 registered
// enable directly; other paths re-time it on their own phase, so all four
// paths count on one common timeline.
module fdiv_path
    import fdiv_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic          clk_set,
    input  logic          clk_clr,
    input  logic          rst_n,
    input  logic          run_in,
    input  logic [CW-1:0] n_act,
    output logic          pulse
);

    logic          run;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot;
    logic          set_tog;
    logic          clr_tog;

    generate
        if (IDX == 0) begin : g_direct
            assign run = run_in;
        end else begin : g_resync
            logic loc_q;
            // Re-time the phase-0 enable onto this path's phase.
            always_ff @(posedge clk_set) begin
                if (!rst_n) loc_q <= 1'b0;
                else        loc_q <= run_in;
            end
            assign run = loc_q;
        end
    endgenerate

    assign slot = slot_of(n_act, IDX);

    // Count modulo N while running and open a pulse in this path's slot.
    always_ff @(posedge clk_set) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            set_tog <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
        end else begin
            if (cnt_q == slot) set_tog <= ~set_tog;
            cnt_q <= (cnt_q == n_act - 1'b1) ? '0 : cnt_q + 1'b1;
        end
    end

    // Close the pulse on the opposite phase.
    always_ff @(posedge clk_clr) begin
        if (!rst_n) clr_tog <= 1'b0;
        else        clr_tog <= set_tog;
    end

    assign pulse = set_tog ^ clr_tog;

    // R2: the counter stays below the modulus
    a_r2_cnt_range : assert property (@(posedge clk_set) disable iff (!rst_n)
        cnt_q < n_act);

    // R3: a pulse opens only from the slot cycle of a running path
    a_r3_fire_in_slot : assert property (@(posedge clk_set) disable iff (!rst_n)
        !$stable(set_tog) |-> ($past(run) && ($past(cnt_q) == $past(slot))));

    // R8: a stopped path holds its counter at zero
    a_r8_idle_zero : assert property (@(posedge clk_set) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/fdiv_quad.sv
`timescale 1ns/1ps
// fdiv_quad: top of the quadrature fractional divider. Four paths, each on
// one phase, are merged with an OR into div_out (period N/4 input periods).
// Assumes phase_clk[k] lags phase_clk[0] by k quarter periods and all
// phases run during reset. trim_q is registered configuration only.
module fdiv_quad
    import fdiv_pkg::*;
#(
    parameter int TRIM_W = 5
) (
    input  logic [NPH-1:0]          phase_clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              n_sel,
    input  logic [2*NPH*TRIM_W-1:0] trim_in,
    output logic                    div_out,
    output logic [2*NPH*TRIM_W-1:0] trim_q
);

    localparam int TW = 2 * NPH * TRIM_W;

    logic          en_q;
    logic [CW-1:0] n_act;
    logic [NPH-1:0] pulse;

    fdiv_ctrl #(.TW(TW)) u_ctrl (
        .clk     (phase_clk[0]),
        .rst_n   (rst_n),
        .en      (en),
        .n_sel   (n_sel),
        .trim_in (trim_in),
        .en_q    (en_q),
        .n_act   (n_act),
        .trim_q  (trim_q)
    );

    generate
        for (genvar k = 0; k < NPH; k++) begin : g_path
            fdiv_path #(.IDX(k)) u_path (
                .clk_set (phase_clk[k]),
                .clk_clr (phase_clk[(k + 2) % NPH]),
                .rst_n   (rst_n),
                .run_in  (en_q),
                .n_act   (n_act),
                .pulse   (pulse[k])
            );
        end
    endgenerate

    assign div_out = |pulse;

    // R4: path pulses never overlap in the merged output
    a_r4_no_overlap : assert property (@(posedge phase_clk[0]) disable iff (!rst_n)
        $onehot0(pulse));

endmodule

// File: tb/tb_fdiv_quad.sv
`timescale 1ns/1ps
module tb_fdiv_quad;

    localparam int TRIM_W = 5;
    localparam int TW     = 8 * TRIM_W;

    typedef struct packed {
        logic [1:0] sel;
        logic [3:0] n_exp;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{sel: 2'b00, n_exp: 4'd3},
        '{sel: 2'b01, n_exp: 4'd5},
        '{sel: 2'b10, n_exp: 4'd7},
        '{sel: 2'b11, n_exp: 4'd7},
        '{sel: 2'b00, n_exp: 4'd3}
    };

    logic [3:0]    ph;
    logic          rst_n;
    logic          en;
    logic [1:0]    n_sel;
    logic [TW-1:0] trim_in;
    logic          div_out;
    logic [TW-1:0] trim_q;

    int      checks;
    int      errors;
    int      rise_cnt;
    realtime t_first, t_last, t_prev, t_hi;

    fdiv_quad #(.TRIM_W(TRIM_W)) dut (
        .phase_clk (ph),
        .rst_n     (rst_n),
        .en        (en),
        .n_sel     (n_sel),
        .trim_in   (trim_in),
        .div_out   (div_out),
        .trim_q    (trim_q)
    );

    // 50 MHz phase 0; phase k lags by k*5 ns
    initial begin
        int q;
        ph = '0;
        q  = 3;
        forever begin
            #5;
            q = (q + 1) % 4;
            for (int k = 0; k < 4; k++) ph[k] = (((q - k + 4) % 4) < 2);
        end
    end

    always @(posedge div_out) begin
        if (rise_cnt == 0) t_first = $realtime;
        rise_cnt = rise_cnt + 1;
        t_prev   = t_last;
        t_last   = $realtime;
    end

    always @(negedge div_out) t_hi = $realtime - t_last;

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // Wait n phase-0 rising edges, then step off the switching grid
    task automatic tick(input int n);
        repeat (n) @(posedge ph[0]);
        #2.5;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual 0 expected 1");
        finish_run();
    end

    initial begin
        int      c0;
        realtime t_en;
        checks = 0; errors = 0; rise_cnt = 0;
        t_first = 0; t_last = 0; t_prev = 0; t_hi = 0;
        rst_n = 1'b0; en = 1'b1; n_sel = 2'b01; trim_in = '0;

        // R1: enable asserted during reset has no effect
        tick(4);
        chk(div_out == 1'b0, "R1", "out in reset", div_out, 0);
        chk(rise_cnt == 0, "R1", "edges in reset", rise_cnt, 0);
        chk(trim_q == '0, "R1", "trim after reset", real'(trim_q), 0);
        en = 1'b0;
        tick(1);
        rst_n = 1'b1;
        tick(10);
        chk(rise_cnt == 0 && div_out == 1'b0, "R1", "idle edges", rise_cnt, 0);

        // R9: trim codes registered on one phase-0 edge
        trim_in = 40'hA5_5A_3C_C3_99;
        tick(1);
        chk(trim_q == 40'hA5_5A_3C_C3_99, "R9", "trim_q", real'(trim_q), real'(40'hA5_5A_3C_C3_99));

        // Table: modulus, ratio, spacing, width, latency
        foreach (VEC[i]) begin
            en = 1'b0;
            tick(3);
            n_sel = VEC[i].sel;
            tick(2);
            rise_cnt = 0;
            en   = 1'b1;
            t_en = $realtime - 2.5;
            tick(8);
            chk(near(t_first, t_en + 40.0), "R7", "first edge time", t_first, t_en + 40.0);
            c0 = rise_cnt;
            tick(24 * int'(VEC[i].n_exp));
            chk(rise_cnt - c0 == 96, "R2", "edges per 24N cycles", rise_cnt - c0, 96);
            chk(near(t_last - t_prev, 5.0 * VEC[i].n_exp), "R3", "edge spacing",
                t_last - t_prev, 5.0 * VEC[i].n_exp);
            chk(near(t_hi, 10.0), "R4", "pulse width", t_hi, 10.0);
            if (VEC[i].sel == 2'b11)
                chk(near(t_last - t_prev, 35.0), "R5", "reserved select kept N=7",
                    t_last - t_prev, 35.0);
        end

        // R6: select changed while running is ignored (running N=3)
        n_sel = 2'b10;
        tick(4);
        c0 = rise_cnt;
        tick(72);
        chk(rise_cnt - c0 == 96, "R6", "edges while sel changed", rise_cnt - c0, 96);
        chk(near(t_last - t_prev, 15.0), "R6", "spacing kept", t_last - t_prev, 15.0);

        // R8: disable stops the output
        en = 1'b0;
        tick(3);
        c0 = rise_cnt;
        tick(10);
        chk(rise_cnt == c0, "R8", "edges after disable", rise_cnt - c0, 0);
        chk(div_out == 1'b0, "R8", "out after disable", div_out, 0);

        // R6: pending select adopted after the stop
        en = 1'b1;
        tick(16);
        chk(near(t_last - t_prev, 35.0), "R6", "pending N=7 adopted", t_last - t_prev, 35.0);

        // R10: reset during operation forces the output low
        rst_n = 1'b0;
        tick(1);
        chk(div_out == 1'b0, "R10", "out one cycle into reset", div_out, 0);
        c0 = rise_cnt;
        tick(3);
        chk(rise_cnt == c0 && div_out == 1'b0, "R10", "edges in reset", rise_cnt - c0, 0);
        rst_n = 1'b1;
        en    = 1'b0;
        tick(2);

        finish_run();
    end

endmodule